// File: doc/BRIEF.md
# Read-Only I2C Slave Transmitter With Fixed Address

This block lets a bus master read a small buffer of decoded bytes over I2C. It never receives data. It watches the SCL and SDA lines using the system clock and detects START and STOP. It takes in the address byte and acknowledges only a read request to its hardwired 7-bit address. It then shifts the buffered bytes onto SDA. Byte 0 goes first, and each byte goes out most significant bit first. SDA is open-drain, so the block only ever pulls it low through an output-enable.

When the request is a write, when the master NACKs, or when the buffer has been fully sent, the slave lets go of SDA. It stays off the bus until a STOP. A busy output covers the span from a matched read request to the STOP. A one-cycle completion pulse after the STOP tells the producer that at least one byte was delivered, so it can refill the buffer.

The controller is a single state machine with these states:
- `ST_IDLE`: waiting for START.
- `ST_ADDR`: taking in the address byte.
- `ST_ADDR_ACK`: driving the address acknowledge.
- `ST_TX`: shifting out a data byte.
- `ST_TX_ACK`: sampling the master's acknowledge.
- `ST_PARK`: SDA released, waiting for STOP.

Its transitions are:
- A STOP moves any state to `ST_IDLE`.
- A START moves any state to `ST_ADDR`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on a matching read, to `ST_PARK` on a matching write, and to `ST_IDLE` on a mismatch.
- `ST_ADDR_ACK` goes to `ST_TX`.
- `ST_TX` goes to `ST_TX_ACK` after eight bits.
- `ST_TX_ACK` goes back to `ST_TX` on an ACK while bytes remain. Otherwise it goes to `ST_PARK`.

Every transition except START and STOP happens on a falling SCL edge.

Top module: `i2ct_slave`

## Requirements
- R1: After reset, `sda_oe`, `busy` and `read_done` are all 0.
- R2: An address byte of 0x4D (7-bit address 0100110 followed by R/W=1, sent MSB first) is acknowledged. SDA is held low during the ninth SCL pulse.
- R3: An address byte whose upper 7 bits differ from 0100110 is not acknowledged and does not set `busy`. SDA stays released until the next START.
- R4: A write request (address byte 0x4C) gets a NACK. SDA stays released for the rest of the transfer until STOP.
- R5: Data goes out MSB first. Byte 0 is `buf_data[8*NUM_BYTES-1 -: 8]`, and each later byte is the next lower 8 bits.
- R6: When the master ACKs (SDA low on the ninth pulse), the next byte follows. When the master NACKs (SDA high), SDA is released until STOP.
- R7: Once all NUM_BYTES bytes have been sent and acknowledged, SDA stays released, so further reads return 0xFF until STOP.
- R8: While `buf_valid` is 0 at byte load, the byte sent is 0xFF.
- R9: `busy` rises when a read request to the address is acknowledged. It stays 1 until a STOP clears it.
- R10: After a STOP, `read_done` pulses for exactly one cycle if at least one data byte of that transfer was acknowledged by the master. Otherwise it stays 0.
- R11: A repeated START at any point discards partial address bits and restarts address reception.
- R12: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| buf_data | input | 8*NUM_BYTES | Buffered bytes, byte 0 in the top 8 bits |
| buf_valid | input | 1 | Buffer holds valid data |
| busy | output | 1 | Read transfer to this slave in progress |
| read_done | output | 1 | One-cycle pulse after STOP of a transfer that delivered data |

## Verification
A pin change reaches the decoded level after two synchroniser flops. The event is formed in the cycle after that, and `sda_oe`, `busy` and `read_done` move on the next edge. Every result therefore lags its bus stimulus by three clock cycles. The bench holds each bus phase for ten cycles and samples SDA in the middle of the SCL high time, long after the slave has settled. `read_done` is counted by a monitor on the falling clock edge. Each scenario compares that count only after waiting well past the STOP, and it checks `busy` only after those same settle windows.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_PARK
    } i2ct_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } i2ct_evt_t;

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], d_in[g]};
            end
        end
        assign q_out[g] = chain[LAST];
    end

endmodule

// File: rtl/i2ct_cond.sv
module i2ct_cond
    import i2ct_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      scl_s,
    input  logic      sda_s,
    output i2ct_evt_t evt
);
    logic scl_d;
    logic sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        evt.start    = scl_s & scl_d & sda_d & ~sda_s;
        evt.stop     = scl_s & scl_d & ~sda_d & sda_s;
        evt.scl_rise = scl_s & ~scl_d;
        evt.scl_fall = ~scl_s & scl_d;
    end

endmodule

// File: rtl/i2ct_fsm.sv
module i2ct_fsm
    import i2ct_pkg::*;
#(
    parameter int         NUM_BYTES  = 2,
    parameter logic [6:0] SLAVE_ADDR = 7'h26
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  i2ct_evt_t              evt,
    input  logic                   scl_s,
    input  logic                   sda_s,
    input  logic [8*NUM_BYTES-1:0] buf_data,
    input  logic                   buf_valid,
    output logic                   sda_oe,
    output logic                   busy,
    output logic                   read_done
);
    localparam int IDX_W   = $clog2(NUM_BYTES + 1);
    localparam int BITS    = 8;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES);

    i2ct_state_e       state_q;
    i2ct_state_e       state_d;
    logic [3:0]        bit_cnt;
    logic [7:0]        shift_q;
    logic [IDX_W-1:0]  byte_idx;
    logic              m_nack;
    logic              acked_any;
    logic              addr_hit;
    logic              byte_done;
    logic [7:0]        cur_byte;
    logic              stop_ev;

    assign stop_ev   = evt.stop;
    assign addr_hit  = (shift_q[7:1] == SLAVE_ADDR);
    assign byte_done = (bit_cnt == 4'(BITS));

    // byte selected for the next load; all ones when the buffer is not valid
    always_comb begin
        cur_byte = 8'hFF;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (byte_idx == IDX_W'(i) && buf_valid) begin
                cur_byte = buf_data[(NUM_BYTES-1-i)*8 +: 8];
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (evt.stop) begin
            state_d = ST_IDLE;
        end else if (evt.start) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_ADDR: begin
                    if (evt.scl_fall && byte_done) begin
                        if (!addr_hit)       state_d = ST_IDLE;
                        else if (shift_q[0]) state_d = ST_ADDR_ACK;
                        else                 state_d = ST_PARK;
                    end
                end
                ST_ADDR_ACK: begin
                    if (evt.scl_fall) state_d = ST_TX;
                end
                ST_TX: begin
                    if (evt.scl_fall && byte_done) state_d = ST_TX_ACK;
                end
                ST_TX_ACK: begin
                    if (evt.scl_fall) begin
                        if (m_nack || byte_idx == LAST_IDX) state_d = ST_PARK;
                        else                                state_d = ST_TX;
                    end
                end
                ST_PARK: state_d = ST_PARK;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe    <= 1'b0;
            busy      <= 1'b0;
            read_done <= 1'b0;
            bit_cnt   <= '0;
            shift_q   <= '0;
            byte_idx  <= '0;
            m_nack    <= 1'b0;
            acked_any <= 1'b0;
        end else begin
            read_done <= 1'b0;
            if (evt.stop) begin
                sda_oe    <= 1'b0;
                busy      <= 1'b0;
                read_done <= acked_any;
                acked_any <= 1'b0;
            end else if (evt.start) begin
                sda_oe   <= 1'b0;
                bit_cnt  <= '0;
                shift_q  <= '0;
                byte_idx <= '0;
                m_nack   <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_ADDR: begin
                        if (evt.scl_rise && !byte_done) begin
                            shift_q <= {shift_q[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                        if (evt.scl_fall && byte_done) begin
                            bit_cnt <= '0;
                            if (addr_hit && shift_q[0]) begin
                                sda_oe <= 1'b1;
                                busy   <= 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (evt.scl_fall) begin
                            shift_q <= cur_byte;
                            sda_oe  <= ~cur_byte[7];
                            bit_cnt <= '0;
                        end
                    end
                    ST_TX: begin
                        if (evt.scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                        if (evt.scl_fall) begin
                            if (byte_done) begin
                                sda_oe  <= 1'b0;
                                bit_cnt <= '0;
                            end else begin
                                shift_q <= {shift_q[6:0], 1'b1};
                                sda_oe  <= ~shift_q[6];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (evt.scl_rise) begin
                            if (!sda_s) begin
                                acked_any <= 1'b1;
                                byte_idx  <= byte_idx + 1'b1;
                            end else begin
                                m_nack <= 1'b1;
                            end
                        end
                        if (evt.scl_fall && state_d == ST_TX) begin
                            shift_q <= cur_byte;
                            sda_oe  <= ~cur_byte[7];
                            bit_cnt <= '0;
                        end
                    end
                    ST_IDLE, ST_PARK: begin
                        sda_oe <= 1'b0;
                    end
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end

    // SDA may only move while the clock line is low
    assert_oe_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    // the slave drives only while acknowledging its address or sending data
    assert_oe_states_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state_q == ST_ADDR_ACK || state_q == ST_TX));

    // parked slave keeps the line released
    assert_park_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARK) |-> !sda_oe);

    // busy only starts together with an address acknowledge
    assert_busy_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (state_q == ST_ADDR_ACK));

    // completion pulse follows a STOP and lasts one cycle
    assert_done_after_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        read_done |-> $past(stop_ev));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        read_done |=> !read_done);

endmodule

// File: rtl/i2ct_slave.sv
module i2ct_slave
    import i2ct_pkg::*;
#(
    parameter int         NUM_BYTES   = 2,
    parameter logic [6:0] SLAVE_ADDR  = 7'h26,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    input  logic [8*NUM_BYTES-1:0] buf_data,
    input  logic                   buf_valid,
    output logic                   busy,
    output logic                   read_done
);
    logic [1:0] line_s;
    i2ct_evt_t  evt;

    i2ct_sync #(
        .WIDTH (2),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in ({scl_i, sda_i}),
        .q_out(line_s)
    );

    i2ct_cond u_cond (
        .clk  (clk),
        .rst_n(rst_n),
        .scl_s(line_s[1]),
        .sda_s(line_s[0]),
        .evt  (evt)
    );

    i2ct_fsm #(
        .NUM_BYTES (NUM_BYTES),
        .SLAVE_ADDR(SLAVE_ADDR)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .scl_s    (line_s[1]),
        .sda_s    (line_s[0]),
        .buf_data (buf_data),
        .buf_valid(buf_valid),
        .sda_oe   (sda_oe),
        .busy     (busy),
        .read_done(read_done)
    );

endmodule

// File: tb/i2ct_slave_tb.sv
module i2ct_slave_tb;
    localparam int NB = 2;
    localparam int Q  = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl_m = 1'b1;
    logic          sda_m = 1'b1;
    logic          sda_oe;
    logic [8*NB-1:0] buf_data = 16'hA53C;
    logic          buf_valid = 1'b1;
    logic          busy;
    logic          read_done;
    wire           sda_line = sda_m & ~sda_oe;

    int total = 0;
    int bad   = 0;
    int done_cnt = 0;
    int oe_viol  = 0;
    logic oe_prev = 1'b0;

    always #5 clk = ~clk;

    i2ct_slave #(.NUM_BYTES(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .buf_data(buf_data), .buf_valid(buf_valid),
        .busy(busy), .read_done(read_done)
    );

    always @(negedge clk) begin
        if (read_done) done_cnt++;
        if (rst_n && sda_oe != oe_prev && scl_m) oe_viol++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pause(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; pause(Q);
        scl_m = 1'b1; pause(Q);
        sda_m = 1'b0; pause(Q);
        scl_m = 1'b0; pause(Q);
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; sda_m = 1'b0; pause(Q);
        scl_m = 1'b1; pause(Q);
        sda_m = 1'b1; pause(4*Q);
    endtask

    task automatic put_bit(input logic b);
        scl_m = 1'b0; sda_m = b; pause(Q);
        scl_m = 1'b1; pause(2*Q);
        scl_m = 1'b0; pause(Q);
    endtask

    task automatic get_bit(output logic b);
        scl_m = 1'b0; sda_m = 1'b1; pause(Q);
        scl_m = 1'b1; pause(Q);
        b = sda_line; pause(Q);
        scl_m = 1'b0; pause(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(ack);
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic m_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(m_ack);
    endtask

    task automatic t_reset();
        chk("R1 sda_oe", 32'(sda_oe), 0);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 read_done", 32'(read_done), 0);
    endtask

    task automatic t_full_read();
        logic ack; logic [7:0] d; int d0 = done_cnt;
        bus_start();
        send_byte(8'h4D, ack);
        chk("R2 address ack", 32'(ack), 0);
        chk("R9 busy after match", 32'(busy), 1);
        recv_byte(d, 1'b0);
        chk("R5 byte0", 32'(d), 32'hA5);
        recv_byte(d, 1'b0);
        chk("R5 byte1", 32'(d), 32'h3C);
        recv_byte(d, 1'b1);
        chk("R7 after last byte", 32'(d), 32'hFF);
        chk("R9 busy before stop", 32'(busy), 1);
        bus_stop();
        chk("R9 busy after stop", 32'(busy), 0);
        chk("R10 done pulse", 32'(done_cnt - d0), 1);
    endtask

    task automatic t_master_nack();
        logic ack; logic [7:0] d; int d0 = done_cnt;
        bus_start();
        send_byte(8'h4D, ack);
        recv_byte(d, 1'b1);
        chk("R6 byte before nack", 32'(d), 32'hA5);
        recv_byte(d, 1'b1);
        chk("R6 released after nack", 32'(d), 32'hFF);
        bus_stop();
        chk("R10 no pulse without ack", 32'(done_cnt - d0), 0);
    endtask

    task automatic t_write_req();
        logic ack; logic [7:0] d; int d0 = done_cnt;
        bus_start();
        send_byte(8'h4C, ack);
        chk("R4 write nack", 32'(ack), 1);
        chk("R4 busy stays low", 32'(busy), 0);
        recv_byte(d, 1'b0);
        chk("R4 line released", 32'(d), 32'hFF);
        bus_stop();
        chk("R4 no pulse", 32'(done_cnt - d0), 0);
    endtask

    task automatic t_mismatch();
        logic ack; logic [7:0] d;
        bus_start();
        send_byte(8'h4F, ack);
        chk("R3 mismatch nack", 32'(ack), 1);
        chk("R3 busy low", 32'(busy), 0);
        recv_byte(d, 1'b0);
        chk("R3 line released", 32'(d), 32'hFF);
        bus_stop();
    endtask

    task automatic t_invalid_buf();
        logic ack; logic [7:0] d; int d0 = done_cnt;
        buf_valid = 1'b0;
        bus_start();
        send_byte(8'h4D, ack);
        chk("R8 ack", 32'(ack), 0);
        recv_byte(d, 1'b0);
        chk("R8 byte0 all ones", 32'(d), 32'hFF);
        recv_byte(d, 1'b1);
        chk("R8 byte1 all ones", 32'(d), 32'hFF);
        bus_stop();
        chk("R10 pulse on invalid read", 32'(done_cnt - d0), 1);
        buf_valid = 1'b1;
    endtask

    task automatic t_restart();
        logic ack; logic [7:0] d;
        bus_start();
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
        bus_start();
        send_byte(8'h4D, ack);
        chk("R11 ack after restart", 32'(ack), 0);
        recv_byte(d, 1'b1);
        chk("R11 data after restart", 32'(d), 32'hA5);
        bus_start();
        send_byte(8'h4D, ack);
        chk("R11 restart after nack", 32'(ack), 0);
        recv_byte(d, 1'b1);
        chk("R11 data second restart", 32'(d), 32'hA5);
        bus_stop();
    endtask

    initial begin
        pause(5);
        rst_n = 1'b1;
        pause(5);
        t_reset();
        t_full_read();
        t_master_nack();
        t_write_req();
        t_mismatch();
        t_invalid_buf();
        t_restart();
        chk("R12 sda_oe moved with SCL high", 32'(oe_viol), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule